// File: doc/BRIEF.md
# Per-Hart Interrupt Priority Selector with Claim

This block serves a wired interrupt domain with several harts. For every hart it keeps a small control window of three registers: a delivery switch, a force bit and a priority threshold. From the pending and enable vectors and each source's target word, it continuously finds the best eligible source for that hart. It then drives that hart's external interrupt line.

Software sees two read-only values per hart. The top value shows the current winner and has no side effects. The claim value returns the same winner and, one cycle later, emits a request that tells the pending-bit owner to drop that source. When the source is a level source whose line is still active, the request asks the owner to keep it pending instead. The pending and enable bits live outside this block. Within one cycle the owner applies the claim request before any other pending update to that source.

A lower priority number is more urgent. The target word of each source carries the hart index in bits 31:18 and the priority in its low bits. Source number 0 does not exist and never wins.

Top module: `hart_prio_sel`

## Requirements
- R1: After reset, every delivery, force and threshold register reads 0, every interrupt line is low, read data is 0 and no claim request is issued.
- R2: A source is eligible for hart h only if its pending and enable bits are both set, bits 31:18 of its target word equal h, and its number is not 0.
- R3: Among eligible sources, the one with the smallest priority (target bits PRIO_W-1:0) wins. On equal priority, the smaller source number wins.
- R4: A nonzero threshold excludes every source whose priority is greater than or equal to it, and a zero threshold excludes nothing. A written threshold is kept to its low PRIO_W bits.
- R5: The top value is the winner's number in bits 16 and up, ORed with its priority in the low bits, or 0 with no winner. Reading it issues no claim request.
- R6: A target priority field of 0 is treated as priority 1 for both selection and reporting.
- R7: A hart's interrupt line is high exactly one cycle after domainIe, its delivery bit and (its force bit or a winner) were all true.
- R8: A claim read returns the top value. In the cycle that read data appears, it also raises clrValid for one cycle with clrId set to the winner.
- R9: clrRepend is 1 with the claim request when the winner is marked level-high and its line is 1, or marked level-low and its line is 0. Otherwise it is 0.
- R10: A claim read with no winner returns 0, issues no request and clears that hart's force bit.
- R11: Hart h's window begins at byte 0x4000 + 32*h, with the delivery bit at offset 0x00 (bit 0), force at 0x04 (bit 0), threshold at 0x08, top at 0x18 and claim at 0x1C. Read data appears one cycle after the read strobe. Misaligned, unmapped or out-of-range accesses read 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| domainIe | input | 1 | Domain-wide interrupt enable |
| srcPending | input | NUM_SRC | Pending bit per source |
| srcEnable | input | NUM_SRC | Enable bit per source |
| srcTarget | input | 32*NUM_SRC | Target word per source (hart 31:18, priority low bits) |
| srcLevelHigh | input | NUM_SRC | Source is sensed as active-high level |
| srcLevelLow | input | NUM_SRC | Source is sensed as active-low level |
| srcLine | input | NUM_SRC | Current raw input line per source |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, one cycle after regRdEn |
| hartIrq | output | NUM_HART | Interrupt line per hart |
| clrValid | output | 1 | Claim request valid |
| clrId | output | ID_W | Source number being claimed |
| clrRepend | output | 1 | Keep the claimed source pending |

## Verification
Assertions check on every cycle that any winner is truly eligible for its hart, that it lies strictly below a nonzero threshold, and that it never reports priority zero. They also check that at most one register strobe fires per access, that a raised line follows a cycle with domain and delivery enabled, and that claim requests follow claim reads and name a real source. An empty claim must leave force clear. Only the bench scenarios can show the full selection order: priority ties resolved by source number, the zero-to-one priority rule seen through the top value, the exact encoding of the returned words, and the re-pend decision for each level sense. The same applies to threshold masking on write and to out-of-window accesses that are ignored.

// File: rtl/hps_pkg.sv
package hps_pkg;

  // Window layout for each hart
  localparam int WIN_BASE    = 32'h4000;
  localparam int WIN_SHIFT   = 5;
  localparam logic [4:0] OFF_DELIV  = 5'h00;
  localparam logic [4:0] OFF_FORCE  = 5'h04;
  localparam logic [4:0] OFF_THRESH = 5'h08;
  localparam logic [4:0] OFF_TOP    = 5'h18;
  localparam logic [4:0] OFF_CLAIM  = 5'h1C;

  // Target word fields that the selector decodes
  localparam int TGT_W        = 32;
  localparam int TGT_HART_LSB = 18;
  localparam int TGT_HART_W   = 14;
  localparam int TOP_ID_LSB   = 16;

  typedef struct packed {
    logic wrDeliv;
    logic wrForce;
    logic wrThresh;
    logic rdDeliv;
    logic rdForce;
    logic rdThresh;
    logic rdTop;
    logic rdClaim;
  } selStrobe_t;

endpackage

// File: rtl/hps_regctl.sv
module hps_regctl
  import hps_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_HART = 4,
  localparam int HSEL_W  = (NUM_HART > 1) ? $clog2(NUM_HART) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output selStrobe_t        stb,
  output logic [HSEL_W-1:0] hartSel
);

  logic [ADDR_W-1:0] relAddr;
  logic [ADDR_W-1:0] winIdx;
  logic              inWin;
  logic [4:0]        offset;

  assign relAddr = regAddr - ADDR_W'(WIN_BASE);
  assign winIdx  = relAddr >> WIN_SHIFT;
  assign inWin   = (regAddr >= ADDR_W'(WIN_BASE)) && (winIdx < ADDR_W'(NUM_HART))
                   && (regAddr[1:0] == 2'b00);
  assign offset  = relAddr[4:0];
  assign hartSel = winIdx[HSEL_W-1:0];

  always_comb begin
    stb = '0;
    if (inWin && regWrEn) begin
      unique case (offset)
        OFF_DELIV:  stb.wrDeliv  = 1'b1;
        OFF_FORCE:  stb.wrForce  = 1'b1;
        OFF_THRESH: stb.wrThresh = 1'b1;
        default: ;
      endcase
    end else if (inWin && regRdEn) begin
      unique case (offset)
        OFF_DELIV:  stb.rdDeliv  = 1'b1;
        OFF_FORCE:  stb.rdForce  = 1'b1;
        OFF_THRESH: stb.rdThresh = 1'b1;
        OFF_TOP:    stb.rdTop    = 1'b1;
        OFF_CLAIM:  stb.rdClaim  = 1'b1;
        default: ;
      endcase
    end
  end

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb));

  assert_strobe_in_window_R11: assert property (@(posedge clk) disable iff (rst)
    (stb != '0) |-> ((regRdEn || regWrEn) && regAddr[1:0] == 2'b00));

endmodule

// File: rtl/hps_tree.sv
module hps_tree
  import hps_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int HART_ID = 0,
  localparam int ID_W   = $clog2(NUM_SRC),
  localparam int LEAVES = 1 << ID_W,
  localparam int NODES  = 2 * LEAVES - 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       srcPending,
  input  logic [NUM_SRC-1:0]       srcEnable,
  input  logic [NUM_SRC*TGT_W-1:0] srcTarget,
  input  logic [PRIO_W-1:0]        thresh,
  output logic                     bestValid,
  output logic [ID_W-1:0]          bestId,
  output logic [PRIO_W-1:0]        bestPrio
);

  logic              nodeValid [NODES];
  logic [ID_W-1:0]   nodeId    [NODES];
  logic [PRIO_W-1:0] nodePrio  [NODES];

  // Leaves: one per source slot, padded slots never valid
  for (genvar s = 0; s < LEAVES; s++) begin : g_leaf
    if (s < NUM_SRC && s != 0) begin : g_real
      logic [TGT_W-1:0]  word;
      logic [PRIO_W-1:0] rawPrio;
      logic [PRIO_W-1:0] effPrio;
      logic              hartHit;
      logic              belowThr;
      assign word     = srcTarget[s*TGT_W +: TGT_W];
      assign rawPrio  = word[PRIO_W-1:0];
      assign effPrio  = (rawPrio == '0) ? PRIO_W'(1) : rawPrio;
      assign hartHit  = word[TGT_HART_LSB +: TGT_HART_W] == TGT_HART_W'(HART_ID);
      assign belowThr = (thresh == '0) || (effPrio < thresh);
      assign nodeValid[LEAVES-1+s] = srcPending[s] && srcEnable[s] && hartHit && belowThr;
      assign nodeId[LEAVES-1+s]    = ID_W'(s);
      assign nodePrio[LEAVES-1+s]  = effPrio;
    end else begin : g_pad
      assign nodeValid[LEAVES-1+s] = 1'b0;
      assign nodeId[LEAVES-1+s]    = ID_W'(s);
      assign nodePrio[LEAVES-1+s]  = '0;
    end
  end

  // Internal nodes: left child holds lower numbers, so it wins ties
  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    logic pickLeft;
    assign pickLeft = nodeValid[2*n+1] &&
                      (!nodeValid[2*n+2] || (nodePrio[2*n+1] <= nodePrio[2*n+2]));
    assign nodeValid[n] = nodeValid[2*n+1] || nodeValid[2*n+2];
    assign nodeId[n]    = pickLeft ? nodeId[2*n+1]   : nodeId[2*n+2];
    assign nodePrio[n]  = pickLeft ? nodePrio[2*n+1] : nodePrio[2*n+2];
  end

  assign bestValid = nodeValid[0];
  assign bestId    = nodeId[0];
  assign bestPrio  = nodePrio[0];

  logic unusedSrc0;
  assign unusedSrc0 = srcPending[0] ^ srcEnable[0] ^ (^srcTarget);

  assert_winner_eligible_R2: assert property (@(posedge clk) disable iff (rst)
    bestValid |-> (bestId != '0 && srcPending[bestId] && srcEnable[bestId] &&
                   srcTarget[32'(bestId)*TGT_W + TGT_HART_LSB +: TGT_HART_W]
                     == TGT_HART_W'(HART_ID)));

  assert_below_threshold_R4: assert property (@(posedge clk) disable iff (rst)
    (bestValid && thresh != '0) |-> (bestPrio < thresh));

  assert_prio_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    bestValid |-> (bestPrio != '0));

endmodule

// File: rtl/hps_datapath.sv
module hps_datapath
  import hps_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_HART = 4,
  parameter int PRIO_W   = 3,
  localparam int ID_W    = $clog2(NUM_SRC),
  localparam int HSEL_W  = (NUM_HART > 1) ? $clog2(NUM_HART) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     domainIe,
  input  logic [NUM_SRC-1:0]       srcPending,
  input  logic [NUM_SRC-1:0]       srcEnable,
  input  logic [NUM_SRC*TGT_W-1:0] srcTarget,
  input  logic [NUM_SRC-1:0]       srcLevelHigh,
  input  logic [NUM_SRC-1:0]       srcLevelLow,
  input  logic [NUM_SRC-1:0]       srcLine,
  input  selStrobe_t               stb,
  input  logic [HSEL_W-1:0]        hartSel,
  input  logic [31:0]              regWrData,
  output logic [31:0]              regRdData,
  output logic [NUM_HART-1:0]      hartIrq,
  output logic                     clrValid,
  output logic [ID_W-1:0]          clrId,
  output logic                     clrRepend
);

  logic [NUM_HART-1:0] delivQ;
  logic [NUM_HART-1:0] forceQ;
  logic [PRIO_W-1:0]   threshQ  [NUM_HART];
  logic [NUM_HART-1:0] candValid;
  logic [ID_W-1:0]     candId   [NUM_HART];
  logic [PRIO_W-1:0]   candPrio [NUM_HART];
  logic [31:0]         topWord  [NUM_HART];

  for (genvar h = 0; h < NUM_HART; h++) begin : g_hart
    hps_tree #(
      .NUM_SRC(NUM_SRC),
      .PRIO_W (PRIO_W),
      .HART_ID(h)
    ) i_tree (
      .clk       (clk),
      .rst       (rst),
      .srcPending(srcPending),
      .srcEnable (srcEnable),
      .srcTarget (srcTarget),
      .thresh    (threshQ[h]),
      .bestValid (candValid[h]),
      .bestId    (candId[h]),
      .bestPrio  (candPrio[h])
    );

    always_comb begin
      topWord[h] = '0;
      if (candValid[h]) begin
        topWord[h][TOP_ID_LSB +: ID_W] = candId[h];
        topWord[h][PRIO_W-1:0]         = candPrio[h];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        delivQ[h]  <= 1'b0;
        forceQ[h]  <= 1'b0;
        threshQ[h] <= '0;
        hartIrq[h] <= 1'b0;
      end else begin
        if (stb.wrDeliv && hartSel == HSEL_W'(h)) delivQ[h] <= regWrData[0];
        if (stb.wrForce && hartSel == HSEL_W'(h)) begin
          forceQ[h] <= regWrData[0];
        end else if (stb.rdClaim && hartSel == HSEL_W'(h) && !candValid[h]) begin
          forceQ[h] <= 1'b0;
        end
        if (stb.wrThresh && hartSel == HSEL_W'(h)) threshQ[h] <= regWrData[PRIO_W-1:0];
        hartIrq[h] <= domainIe && delivQ[h] && (forceQ[h] || candValid[h]);
      end
    end
  end

  // Read multiplexer
  logic [31:0]     rdNext;
  logic [ID_W-1:0] selId;
  logic            selValid;
  assign selId    = candId[hartSel];
  assign selValid = candValid[hartSel];

  always_comb begin
    rdNext = '0;
    if (stb.rdDeliv)  rdNext[0] = delivQ[hartSel];
    if (stb.rdForce)  rdNext[0] = forceQ[hartSel];
    if (stb.rdThresh) rdNext[PRIO_W-1:0] = threshQ[hartSel];
    if (stb.rdTop || stb.rdClaim) rdNext = topWord[hartSel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regRdData <= '0;
      clrValid  <= 1'b0;
      clrId     <= '0;
      clrRepend <= 1'b0;
    end else begin
      regRdData <= rdNext;
      clrValid  <= stb.rdClaim && selValid;
      clrId     <= (stb.rdClaim && selValid) ? selId : '0;
      clrRepend <= stb.rdClaim && selValid &&
                   ((srcLevelHigh[selId] && srcLine[selId]) ||
                    (srcLevelLow[selId] && !srcLine[selId]));
    end
  end

  logic unusedWrData;
  assign unusedWrData = ^regWrData;

  for (genvar h = 0; h < NUM_HART; h++) begin : g_chk
    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
      hartIrq[h] |-> $past(domainIe && delivQ[h]));
  end

  assert_clr_after_claim_R8: assert property (@(posedge clk) disable iff (rst)
    clrValid |-> ($past(stb.rdClaim) && clrId != '0));

  assert_empty_claim_clears_force_R10: assert property (@(posedge clk) disable iff (rst)
    (stb.rdClaim && !selValid) |=> (forceQ[$past(hartSel)] == 1'b0 && !clrValid));

endmodule

// File: rtl/hart_prio_sel.sv
module hart_prio_sel
  import hps_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_HART = 4,
  parameter int PRIO_W   = 3,
  parameter int ADDR_W   = 16,
  localparam int ID_W    = $clog2(NUM_SRC),
  localparam int HSEL_W  = (NUM_HART > 1) ? $clog2(NUM_HART) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     domainIe,
  input  logic [NUM_SRC-1:0]       srcPending,
  input  logic [NUM_SRC-1:0]       srcEnable,
  input  logic [NUM_SRC*32-1:0]    srcTarget,
  input  logic [NUM_SRC-1:0]       srcLevelHigh,
  input  logic [NUM_SRC-1:0]       srcLevelLow,
  input  logic [NUM_SRC-1:0]       srcLine,
  input  logic                     regWrEn,
  input  logic                     regRdEn,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [31:0]              regWrData,
  output logic [31:0]              regRdData,
  output logic [NUM_HART-1:0]      hartIrq,
  output logic                     clrValid,
  output logic [ID_W-1:0]          clrId,
  output logic                     clrRepend
);

  selStrobe_t        stb;
  logic [HSEL_W-1:0] hartSel;

  hps_regctl #(
    .ADDR_W  (ADDR_W),
    .NUM_HART(NUM_HART)
  ) i_regctl (
    .clk    (clk),
    .rst    (rst),
    .regWrEn(regWrEn),
    .regRdEn(regRdEn),
    .regAddr(regAddr),
    .stb    (stb),
    .hartSel(hartSel)
  );

  hps_datapath #(
    .NUM_SRC (NUM_SRC),
    .NUM_HART(NUM_HART),
    .PRIO_W  (PRIO_W)
  ) i_datapath (
    .clk         (clk),
    .rst         (rst),
    .domainIe    (domainIe),
    .srcPending  (srcPending),
    .srcEnable   (srcEnable),
    .srcTarget   (srcTarget),
    .srcLevelHigh(srcLevelHigh),
    .srcLevelLow (srcLevelLow),
    .srcLine     (srcLine),
    .stb         (stb),
    .hartSel     (hartSel),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .hartIrq     (hartIrq),
    .clrValid    (clrValid),
    .clrId       (clrId),
    .clrRepend   (clrRepend)
  );

endmodule

// File: tb/test_hart_prio_sel.sv
module test_hart_prio_sel;

  localparam int NUM_SRC  = 32;
  localparam int NUM_HART = 4;
  localparam int PRIO_W   = 3;
  localparam int ADDR_W   = 16;
  localparam int ID_W     = $clog2(NUM_SRC);

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  domainIe = 1'b0;
  logic [NUM_SRC-1:0]    srcPending = '0;
  logic [NUM_SRC-1:0]    srcEnable = '0;
  logic [NUM_SRC*32-1:0] srcTarget = '0;
  logic [NUM_SRC-1:0]    srcLevelHigh = '0;
  logic [NUM_SRC-1:0]    srcLevelLow = '0;
  logic [NUM_SRC-1:0]    srcLine = '0;
  logic                  regWrEn = 1'b0;
  logic                  regRdEn = 1'b0;
  logic [ADDR_W-1:0]     regAddr = '0;
  logic [31:0]           regWrData = '0;
  logic [31:0]           regRdData;
  logic [NUM_HART-1:0]   hartIrq;
  logic                  clrValid;
  logic [ID_W-1:0]       clrId;
  logic                  clrRepend;

  always #2.5 clk = ~clk;

  hart_prio_sel #(
    .NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
  ) i_hart_prio_sel (
    .clk(clk), .rst(rst), .domainIe(domainIe),
    .srcPending(srcPending), .srcEnable(srcEnable), .srcTarget(srcTarget),
    .srcLevelHigh(srcLevelHigh), .srcLevelLow(srcLevelLow), .srcLine(srcLine),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .hartIrq(hartIrq),
    .clrValid(clrValid), .clrId(clrId), .clrRepend(clrRepend)
  );

  int compared = 0;
  int mismatched = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];
  expItem_t curItem;
  logic     sawRd = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare read data against queued expectations
  always @(posedge clk) sawRd <= regRdEn;
  always @(negedge clk) begin
    if (sawRd) begin
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL R11 actual=unexpected read expected=queued item");
      end else begin
        curItem = expQ.pop_front();
        check(curItem.tag, regRdData, curItem.exp);
      end
    end
  end

  function automatic logic [ADDR_W-1:0] winAddr(int hart, int off);
    return ADDR_W'(32'h4000 + hart * 32 + off);
  endfunction

  function automatic logic [31:0] tgtWord(int hart, int prio);
    return (32'(hart) << 18) | 32'(prio);
  endfunction

  function automatic logic [31:0] topVal(int id, int prio);
    return (32'(id) << 16) | 32'(prio);
  endfunction

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
    expItem_t it;
    it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic claim(int hart, logic [31:0] exp, logic expValid, int expId,
                       logic expRep, string tag);
    rd(winAddr(hart, 'h1C), exp, tag);
    check({tag, " clrValid"}, 32'(clrValid), 32'(expValid));
    if (expValid) begin
      check({tag, " clrId"}, 32'(clrId), 32'(expId));
      check({tag, " clrRepend"}, 32'(clrRepend), 32'(expRep));
    end
  endtask

  task automatic setSrc(int s, int hart, int prio, logic pend, logic en);
    srcTarget[s*32 +: 32] = tgtWord(hart, prio);
    srcPending[s] = pend;
    srcEnable[s]  = en;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();

    // R1: reset state
    check("R1 irq", 32'(hartIrq), 32'h0);
    check("R1 clrValid", 32'(clrValid), 32'h0);
    check("R1 rdData", regRdData, 32'h0);
    rd(winAddr(0, 'h00), 32'h0, "R1 deliv");
    rd(winAddr(0, 'h04), 32'h0, "R1 force");
    rd(winAddr(0, 'h08), 32'h0, "R1 thresh");
    rd(winAddr(0, 'h18), 32'h0, "R1 top");

    // R4 / R11: register access, masking, out-of-window
    wr(winAddr(1, 'h08), 32'hFF);
    rd(winAddr(1, 'h08), 32'h7, "R4 thresh masked");
    wr(winAddr(1, 'h00), 32'h3);
    rd(winAddr(1, 'h00), 32'h1, "R11 deliv bit0");
    rd(winAddr(0, 'h0C), 32'h0, "R11 unmapped offset");
    rd(winAddr(4, 'h00), 32'h0, "R11 hart out of range");
    wr(winAddr(0, 'h00) + 1, 32'h1);
    rd(winAddr(0, 'h00), 32'h0, "R11 misaligned write ignored");
    wr(winAddr(1, 'h08), 32'h0);
    wr(winAddr(1, 'h00), 32'h0);

    // R2: eligibility
    setSrc(5, 0, 3, 1'b1, 1'b1);
    rd(winAddr(0, 'h18), topVal(5, 3), "R2 single candidate");
    rd(winAddr(1, 'h18), 32'h0, "R2 other hart empty");
    setSrc(6, 0, 1, 1'b1, 1'b0);
    rd(winAddr(0, 'h18), topVal(5, 3), "R2 disabled source skipped");
    setSrc(8, 1, 1, 1'b1, 1'b1);
    rd(winAddr(0, 'h18), topVal(5, 3), "R2 foreign hart skipped");
    rd(winAddr(1, 'h18), topVal(8, 1), "R2 hart1 winner");
    setSrc(0, 0, 1, 1'b1, 1'b1);
    rd(winAddr(0, 'h18), topVal(5, 3), "R2 source zero never wins");

    // R3: lower priority wins, tie to lower number
    setSrc(9, 0, 2, 1'b1, 1'b1);
    setSrc(7, 0, 2, 1'b1, 1'b1);
    rd(winAddr(0, 'h18), topVal(7, 2), "R3 tie lower number");

    // R6: zero priority treated as 1
    setSrc(12, 0, 0, 1'b1, 1'b1);
    rd(winAddr(0, 'h18), topVal(12, 1), "R6 zero prio as one");

    // R4: threshold filtering
    wr(winAddr(0, 'h08), 32'h2);
    rd(winAddr(0, 'h18), topVal(12, 1), "R4 below threshold kept");
    wr(winAddr(0, 'h08), 32'h1);
    rd(winAddr(0, 'h18), 32'h0, "R4 equal threshold excluded");
    wr(winAddr(0, 'h08), 32'h0);
    rd(winAddr(0, 'h18), topVal(12, 1), "R4 zero threshold");

    // R7: interrupt line
    domainIe = 1'b1;
    wr(winAddr(0, 'h00), 32'h1);
    settle();
    check("R7 irq hart0 on", 32'(hartIrq), 32'h1);
    srcPending[8] = 1'b0;
    wr(winAddr(1, 'h00), 32'h1);
    settle();
    check("R7 no candidate no irq", 32'(hartIrq), 32'h1);
    wr(winAddr(1, 'h04), 32'h1);
    settle();
    check("R7 force raises irq", 32'(hartIrq), 32'h3);
    domainIe = 1'b0;
    settle();
    check("R7 domain disable", 32'(hartIrq), 32'h0);
    domainIe = 1'b1;
    settle();
    check("R7 domain re-enable", 32'(hartIrq), 32'h3);

    // R5: top read has no side effects
    rd(winAddr(0, 'h18), topVal(12, 1), "R5 top read one");
    check("R5 no request", 32'(clrValid), 32'h0);
    rd(winAddr(0, 'h18), topVal(12, 1), "R5 top read two");
    check("R5 still no request", 32'(clrValid), 32'h0);

    // R8: claim of an edge source
    claim(0, topVal(12, 1), 1'b1, 12, 1'b0, "R8 claim edge");
    srcPending[12] = 1'b0;
    settle();
    check("R8 single pulse", 32'(clrValid), 32'h0);

    // R9: level sources re-pend while active
    srcLevelHigh[7] = 1'b1; srcLine[7] = 1'b1;
    claim(0, topVal(7, 2), 1'b1, 7, 1'b1, "R9 level-high active");
    srcLine[7] = 1'b0;
    claim(0, topVal(7, 2), 1'b1, 7, 1'b0, "R9 level-high idle");
    srcPending[7] = 1'b0;
    srcLevelLow[9] = 1'b1; srcLine[9] = 1'b0;
    claim(0, topVal(9, 2), 1'b1, 9, 1'b1, "R9 level-low active");
    srcLine[9] = 1'b1;
    claim(0, topVal(9, 2), 1'b1, 9, 1'b0, "R9 level-low idle");
    srcPending[9] = 1'b0;
    rd(winAddr(0, 'h18), topVal(5, 3), "R8 next winner after claims");

    // R10: empty claim clears force
    claim(1, 32'h0, 1'b0, 0, 1'b0, "R10 empty claim");
    rd(winAddr(1, 'h04), 32'h0, "R10 force cleared");
    check("R10 irq drops", 32'(hartIrq), 32'h1);

    settle();
    finishRun();
  end

endmodule